// File: doc/BRIEF.md
# Iterative 16-bit Multiply/Divide Unit

This block is a sequential arithmetic engine for 16-bit operands. A one-cycle start pulse loads both operands and a 2-bit operation code. The unit then works through its iterations while `busy` is high. It ends with a single-cycle `done` pulse, and the 16-bit answer appears on `result` in that same cycle.

Multiplication uses shift-and-add. It adds the shifted multiplicand whenever the current multiplier bit is set. It stops as soon as no set bits remain in the multiplier, so the number of cycles depends on the data. Division is restoring long division: one quotient bit per cycle, always sixteen iterations.

Signed operations first turn both operands into magnitudes. At the end the result is negated when the operand signs differ.

Top module: `iter_muldiv`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `result` are all zero until the first operation completes.
- R2: `op` encoding: 2'b00 unsigned multiply, 2'b01 signed multiply, 2'b10 unsigned divide, 2'b11 signed divide. An unsigned multiply returns the low 16 bits of `a*b`.
- R3: A signed multiply treats both operands as two's complement and returns the low 16 bits of the signed product.
- R4: An unsigned divide with a nonzero divisor returns the quotient `a/b`, rounded down.
- R5: A signed divide with a nonzero divisor returns the two's-complement quotient, truncated toward zero; for example -7/2 gives 0xFFFD.
- R6: A divide by zero, signed or unsigned, returns 0xFFFF and otherwise behaves like any other divide.
- R7: A multiply keeps `busy` high for P cycles. P is the 1-based position of the highest set bit of the second operand, using its magnitude for a signed multiply. A zero second operand gives P = 1 and result 0.
- R8: A divide keeps `busy` high for exactly 16 cycles.
- R9: A start pulse accepted while idle raises `busy` in the next cycle. `done` is high for one cycle, in the cycle right after `busy` falls, and a new start may be given in that cycle.
- R10: A start pulse given while `busy` is high is ignored: the running operation's timing and result are unchanged.
- R11: `result` keeps its value from one `done` pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | Operation select, encoding in R2 |
| opa | input | 16 | First operand (multiplicand / dividend) |
| opb | input | 16 | Second operand (multiplier / divisor) |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Product low half or quotient |

## Verification
A bad iteration counter or a stale multiplier register shows up first as a `done` pulse in the wrong cycle. The bench compares `busy` and `done` against its model on every clock, so such a fault is caught in the very cycle the edge moves. A wrong accumulator, remainder or sign flag stays hidden until completion. It then shows as a wrong `result` in the `done` cycle, no later than 17 cycles after the start. Sign faults show only on the mixed-sign, most-negative and divide-by-zero cases, which is why the bench feeds those on purpose.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
    typedef enum logic [1:0] {
        OP_MULU = 2'b00,
        OP_MULS = 2'b01,
        OP_DIVU = 2'b10,
        OP_DIVS = 2'b11
    } md_op_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } md_phase_e;
endpackage

// File: rtl/md_operand_prep.sv
module md_operand_prep #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_signed,
    input  logic         is_div,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg
);
    logic a_neg, b_neg, div_zero;

    always_comb begin
        a_neg    = is_signed & a[W-1];
        b_neg    = is_signed & b[W-1];
        mag_a    = a_neg ? (~a + 1'b1) : a;
        mag_b    = b_neg ? (~b + 1'b1) : b;
        div_zero = is_div & (b == '0);
        // the all-ones quotient for a zero divisor is never negated
        neg      = (a_neg ^ b_neg) & ~div_zero;
    end
endmodule

// File: rtl/md_mul_step.sv
module md_mul_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic [W-1:0] acc_n,
    output logic [W-1:0] mcand_n,
    output logic [W-1:0] mplier_n,
    output logic         last
);
    always_comb begin
        acc_n    = mplier[0] ? (acc + mcand) : acc;
        mcand_n  = {mcand[W-2:0], 1'b0};
        mplier_n = {1'b0, mplier[W-1:1]};
        last     = (mplier_n == '0);
    end
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] rem_n,
    output logic [W-1:0] quo_n
);
    logic [W:0]   shifted;
    logic [W+1:0] trial;
    logic         fits;

    always_comb begin
        shifted = {rem, quo[W-1]};
        trial   = {1'b0, shifted} - {2'b00, dvsr};
        fits    = ~trial[W+1];
        rem_n   = fits ? trial[W-1:0] : shifted[W-1:0];
        quo_n   = {quo[W-2:0], fits};
    end
endmodule

// File: rtl/iter_muldiv.sv
module iter_muldiv
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_DIV = CNT_W'(W - 1);

    typedef struct packed {
        md_phase_e        phase;
        logic             is_div;
        logic             neg;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     acc;   // product accumulator or remainder
        logic [W-1:0]     opx;   // multiplicand or divisor
        logic [W-1:0]     opy;   // multiplier or dividend/quotient
        logic [W-1:0]     res;
        logic             done;
    } md_state_t;

    md_state_t st_d, st_q;

    logic [W-1:0] mag_a, mag_b;
    logic         prep_neg;
    logic [W-1:0] m_acc_n, m_mcand_n, m_mplier_n;
    logic         m_last;
    logic [W-1:0] d_rem_n, d_quo_n;
    logic [W-1:0] fin_val;
    logic         fin;

    md_operand_prep #(.W(W)) u_prep (
        .a         (opa),
        .b         (opb),
        .is_signed (op[0]),
        .is_div    (op[1]),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg       (prep_neg)
    );

    md_mul_step #(.W(W)) u_mul (
        .acc      (st_q.acc),
        .mcand    (st_q.opx),
        .mplier   (st_q.opy),
        .acc_n    (m_acc_n),
        .mcand_n  (m_mcand_n),
        .mplier_n (m_mplier_n),
        .last     (m_last)
    );

    md_div_step #(.W(W)) u_div (
        .rem   (st_q.acc),
        .quo   (st_q.opy),
        .dvsr  (st_q.opx),
        .rem_n (d_rem_n),
        .quo_n (d_quo_n)
    );

    always_comb begin
        st_d    = st_q;
        st_d.done = 1'b0;
        fin     = 1'b0;
        fin_val = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase  = PH_RUN;
                    st_d.is_div = op[1];
                    st_d.neg    = prep_neg;
                    st_d.cnt    = '0;
                    st_d.acc    = '0;
                    st_d.opx    = op[1] ? mag_b : mag_a;
                    st_d.opy    = op[1] ? mag_a : mag_b;
                end
            end
            PH_RUN: begin
                if (st_q.is_div) begin
                    st_d.acc = d_rem_n;
                    st_d.opy = d_quo_n;
                    st_d.cnt = st_q.cnt + 1'b1;
                    fin      = (st_q.cnt == LAST_DIV);
                    fin_val  = d_quo_n;
                end else begin
                    st_d.acc = m_acc_n;
                    st_d.opx = m_mcand_n;
                    st_d.opy = m_mplier_n;
                    fin      = m_last;
                    fin_val  = m_acc_n;
                end
                if (fin) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.res   = st_q.neg ? (~fin_val + 1'b1) : fin_val;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.phase == PH_RUN);
    assign done   = st_q.done;
    assign result = st_q.res;
endmodule

// File: rtl/iter_muldiv_checker.sv
module iter_muldiv_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    function automatic logic [7:0] top_bit_pos(input logic [W-1:0] v);
        logic [7:0] p;
        p = 8'd1;
        for (int i = 0; i < W; i++) begin
            if (v[i]) p = 8'(i + 1);
        end
        return p;
    endfunction

    logic [7:0] busy_cycles;
    logic [7:0] lat_exp;
    logic       was_div;
    logic [W-1:0] mag_b;

    assign mag_b = (op[0] && opb[W-1]) ? (~opb + 1'b1) : opb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cycles <= '0;
            lat_exp     <= 8'd1;
            was_div     <= 1'b0;
        end else if (start && !busy) begin
            busy_cycles <= '0;
            was_div     <= op[1];
            lat_exp     <= op[1] ? 8'(W) : top_bit_pos(mag_b);
        end else if (busy) begin
            busy_cycles <= busy_cycles + 1'b1;
        end
    end

    p_mul_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !was_div) |-> (busy_cycles == lat_exp));

    p_div_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && was_div) |-> (busy_cycles == 8'(W)));

    p_busy_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (busy || done));

    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

bind iter_muldiv iter_muldiv_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .opa    (opa),
    .opb    (opb),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/iter_muldiv_tb.sv
module iter_muldiv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        busy, done;
    logic [15:0] result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit compare_on = 1'b0;

    always #2.5 clk = ~clk;

    iter_muldiv u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .busy(busy), .done(done), .result(result)
    );

    function automatic logic [15:0] ref_res(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b);
        longint sa, sb, r;
        sa = o[0] ? longint'($signed(a)) : longint'(a);
        sb = o[0] ? longint'($signed(b)) : longint'(b);
        if (!o[1])        r = sa * sb;
        else if (b == 0)  r = 64'hFFFF;
        else              r = sa / sb;
        return r[15:0];
    endfunction

    function automatic int ref_lat(input logic [1:0] o, input logic [15:0] b);
        longint m;
        int p;
        if (o[1]) return 16;
        m = (o[0] && b[15]) ? -longint'($signed(b)) : longint'(b);
        p = 1;
        for (int i = 0; i < 17; i++) if (m[i]) p = i + 1;
        return p;
    endfunction

    // behavioural reference: busy countdown and expected output registers
    bit          busy_m = 0, done_m = 0;
    int          cnt_m = 0;
    logic [15:0] res_m = '0, pend_m = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_m <= 0; done_m <= 0; cnt_m <= 0; res_m <= '0; pend_m <= '0;
        end else begin
            done_m <= 0;
            if (busy_m) begin
                if (cnt_m == 1) begin
                    busy_m <= 0; done_m <= 1; res_m <= pend_m;
                end
                cnt_m <= cnt_m - 1;
            end else if (start) begin
                busy_m <= 1;
                cnt_m  <= ref_lat(op, opb);
                pend_m <= ref_res(op, opa, opb);
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (compare_on) begin
            check("R9",  16'(busy), 16'(busy_m), "busy");
            check("R9",  16'(done), 16'(done_m), "done");
            check("R11", result, res_m, "result");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL R9 watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic run_op(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b,
                          input string tag, input bit poke_busy);
        int nb;
        logic [15:0] exp;
        exp = ref_res(o, a, b);
        @(negedge clk);
        start = 1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 0;
        nb = 0;
        while (!done) begin
            if (busy) nb++;
            if (poke_busy && nb == 1) begin
                start = 1; op = ~o; opa = ~a; opb = b ^ 16'h0005; // R10 stray start
            end else begin
                start = 0;
            end
            @(negedge clk);
        end
        start = 0;
        check(tag, result, exp, $sformatf("op=%0d a=%h b=%h result", o, a, b));
        check(o[1] ? "R8" : "R7", 16'(nb), 16'(ref_lat(o, b)), "busy cycles");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 16'(busy), 16'h0, "busy in reset");
        check("R1", 16'(done), 16'h0, "done in reset");
        check("R1", result, 16'h0, "result in reset");
        rst_n = 1;
        @(negedge clk);
        compare_on = 1;
        check("R1", result, 16'h0, "result after reset");

        run_op(2'b00, 16'd300, 16'd7, "R2", 0);
        run_op(2'b00, 16'hFFFF, 16'hFFFF, "R2", 0);
        run_op(2'b00, 16'h1234, 16'h0000, "R7", 0);
        run_op(2'b00, 16'h0055, 16'h0001, "R7", 0);
        run_op(2'b00, 16'h0003, 16'h8000, "R7", 0);
        run_op(2'b01, 16'hFFF9, 16'd6, "R3", 0);
        run_op(2'b01, 16'h8000, 16'hFFFF, "R3", 0);
        run_op(2'b01, 16'hFFFD, 16'hFFFB, "R3", 0);
        run_op(2'b01, 16'd5, 16'h8000, "R3", 0);
        run_op(2'b10, 16'd1000, 16'd7, "R4", 0);
        run_op(2'b10, 16'hFFFF, 16'd1, "R4", 0);
        run_op(2'b10, 16'd3, 16'd9, "R4", 0);
        run_op(2'b11, 16'hFFF9, 16'd2, "R5", 0);
        run_op(2'b11, 16'd7, 16'hFFFE, "R5", 0);
        run_op(2'b11, 16'h8000, 16'hFFFF, "R5", 0);
        run_op(2'b10, 16'd1234, 16'd0, "R6", 0);
        run_op(2'b11, 16'hFF00, 16'd0, "R6", 0);
        run_op(2'b00, 16'd25, 16'd40, "R10", 1);
        run_op(2'b10, 16'd5000, 16'd13, "R10", 1);
        // back-to-back: new start given in the done cycle
        run_op(2'b11, 16'd100, 16'hFFF6, "R9", 0);
        run_op(2'b01, 16'd12, 16'hFFFE, "R9", 0);
        repeat (5) @(negedge clk);  // idle: result must hold (R11)
        check("R11", result, ref_res(2'b01, 16'd12, 16'hFFFE), "held result");

        for (int k = 0; k < 300; k++) begin
            logic [1:0]  ro;
            logic [15:0] ra, rb;
            ro = 2'($urandom);
            ra = 16'($urandom);
            rb = 16'($urandom);
            if (k % 7 == 0) rb = rb >> ($urandom % 16);
            run_op(ro, ra, rb, ro[1] ? (ro[0] ? "R5" : "R4") : (ro[0] ? "R3" : "R2"), 0);
        end

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule